// File: doc/BRIEF.md
# USB Endpoint Control Register Bank

This block holds the per-endpoint 16-bit control and status words of a full-speed USB device endpoint engine. It also holds the base pointer of the buffer-descriptor table. A CPU reads and writes the bank through a plain word bus. Within one word, different fields follow different write rules:

- The status and data-toggle fields flip where a 1 is written.
- The two completion flags clear where a 0 is written.
- The type, kind and address fields take the written value.
- The SETUP flag ignores the CPU.

The transaction engine reports completed OUT and IN transactions through an event port. That port can change the same bits in the same cycle as a CPU write.

For OUT events the engine presents the endpoint's receive descriptor. The block decodes the block-size and block-count fields of that descriptor into a byte capacity. It compares the received byte count against that capacity. A packet that does not fit raises a one-cycle overflow pulse and leaves the endpoint word untouched.

The whole bank is also exported flat, so the engine can see every endpoint's status and toggles.

Top module: `usb_epreg_bank`

## Requirements
- R1: After a synchronous active-low reset, every endpoint word and the table base read 0, and `rx_ovf_o` is 0.
- R2: Endpoint word n is at byte offset 4*n. Bits 10:9 (type: 00 bulk, 01 control, 10 isochronous, 11 interrupt), bit 8 (kind) and bits 3:0 (address) take the written value.
- R3: Bits 14 (RX toggle), 13:12 (RX status), 6 (TX toggle) and 5:4 (TX status) invert where a 1 is written and hold where a 0 is written. The status code is 00 disabled, 01 stall, 10 NAK, 11 valid.
- R4: Bit 15 (RX done) and bit 7 (TX done) clear when written 0 and hold when written 1.
- R5: Bit 11 (SETUP seen) is unchanged by any CPU write.
- R6: The table base sits at offset 0x50 and its bits 2:0 always read 0. Offsets that map to no register read 0.
- R7: An accepted OUT event for endpoint `ev_ep` sets bit 15, inverts bit 14, forces bits 13:12 to 10 (NAK) and loads bit 11 with `ev_setup`. The word reads back changed one cycle later, and other endpoints are unchanged.
- R8: An IN event for endpoint `ev_ep` sets bit 7, inverts bit 6 and forces bits 5:4 to 10 (NAK). The word reads back changed one cycle later.
- R9: When a CPU write of 0 to a completion flag meets an event setting that flag in the same cycle, the flag ends set.
- R10: `rx_cap_o` decodes `ev_desc`. With bit 15 clear it is 2 times bits 14:10. With bit 15 set it is 32 times (bits 14:10 + 1).
- R11: An OUT event whose count (`ev_desc` bits 9:0) exceeds the decoded capacity leaves the endpoint word unchanged. It drives `rx_ovf_o` high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | CPU byte address |
| bus_we | input | 1 | CPU write strobe |
| bus_wdata | input | 16 | CPU write data |
| bus_rdata | output | 16 | CPU read data, combinational from `bus_addr` |
| ev_ep | input | 4 | Endpoint number of the event |
| ev_rx | input | 1 | OUT transaction completed |
| ev_setup | input | 1 | The completed OUT was a SETUP |
| ev_tx | input | 1 | IN transaction completed |
| ev_desc | input | 16 | Receive descriptor: count in 9:0, block count in 14:10, block size in 15 |
| rx_cap_o | output | 11 | Decoded receive capacity in bytes |
| rx_ovf_o | output | 1 | Overflow pulse for the previous cycle's OUT event |
| ep_regs_o | output | 16*NUM_EP | All endpoint words, endpoint n in bits 16n+15:16n |

## Verification
CPU writes and hardware events take effect at the clock edge that samples them. Because `bus_rdata` is combinational, the new word is readable right after that edge.

`rx_cap_o` follows `ev_desc` with no clock at all. `rx_ovf_o` is registered, so it is high only in the cycle after the offending event.

The bench drives every stimulus on the falling edge. It reads back after the next rising edge and before the one after that. It samples the overflow output both one and two cycles after the event, which confirms the pulse width.

// File: rtl/usbep_pkg.sv
// Package: shared bit positions and encodings for the endpoint word.
// Assumes a 16-bit endpoint word with a fixed field layout that the
// transaction engine decodes.
package usbep_pkg;

    localparam int WORD_W   = 16;
    localparam int CAP_W    = 11;

    localparam int B_RXDONE = 15;
    localparam int B_RXTGL  = 14;
    localparam int B_RXST_H = 13;
    localparam int B_RXST_L = 12;
    localparam int B_SETUP  = 11;
    localparam int B_TXDONE = 7;
    localparam int B_TXTGL  = 6;
    localparam int B_TXST_H = 5;
    localparam int B_TXST_L = 4;

    typedef enum logic [1:0] {
        ST_OFF   = 2'b00,
        ST_STALL = 2'b01,
        ST_NAK   = 2'b10,
        ST_READY = 2'b11
    } ep_stat_e;

endpackage

// File: rtl/usbep_cap_decode.sv
// Module: receive-descriptor capacity decoder.
// Turns the block-size flag and the 5-bit block count into a byte capacity.
// Purely combinational; assumes the descriptor is stable while it is used.
module usbep_cap_decode
    import usbep_pkg::*;
(
    input  logic [WORD_W-1:0] desc,
    output logic [CAP_W-1:0]  cap
);

    logic [4:0] blocks;
    logic       big_blk;

    assign blocks  = desc[14:10];
    assign big_blk = desc[15];

    // Purpose: 2-byte blocks when the size flag is clear, 32-byte blocks (count+1) when set.
    always_comb begin
        if (big_blk) begin
            cap = CAP_W'({1'b0, blocks} + 6'd1) << 5;
        end else begin
            cap = CAP_W'({blocks, 1'b0});
        end
    end

    // R10: the decoded capacity never exceeds the largest encodable buffer
    always_comb begin
        p_cap_range_r10: assert (cap <= CAP_W'(1024));
    end

endmodule

// File: rtl/usbep_ep_word.sv
// Module: one endpoint control/status word.
// Applies the CPU write first (rw, invert-on-one or clear-on-zero per field),
// then the hardware event on top of it, so a hardware set always wins.
// Assumes the event strobes are already qualified for this endpoint.
module usbep_ep_word
    import usbep_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    input  logic              rx_hit,
    input  logic              rx_setup,
    input  logic              tx_hit,
    output logic [WORD_W-1:0] q
);

    logic [WORD_W-1:0] nxt;

    // Purpose: compute the next word from CPU write rules, then the event overlay.
    always_comb begin
        nxt = q;
        if (wr_en) begin
            nxt[B_RXDONE]          = q[B_RXDONE] & wdata[B_RXDONE];
            nxt[B_RXTGL]           = q[B_RXTGL] ^ wdata[B_RXTGL];
            nxt[B_RXST_H:B_RXST_L] = q[B_RXST_H:B_RXST_L] ^ wdata[B_RXST_H:B_RXST_L];
            nxt[10:8]              = wdata[10:8];
            nxt[B_TXDONE]          = q[B_TXDONE] & wdata[B_TXDONE];
            nxt[B_TXTGL]           = q[B_TXTGL] ^ wdata[B_TXTGL];
            nxt[B_TXST_H:B_TXST_L] = q[B_TXST_H:B_TXST_L] ^ wdata[B_TXST_H:B_TXST_L];
            nxt[3:0]               = wdata[3:0];
        end
        if (rx_hit) begin
            nxt[B_RXDONE]          = 1'b1;
            nxt[B_RXTGL]           = ~nxt[B_RXTGL];
            nxt[B_RXST_H:B_RXST_L] = ST_NAK;
            nxt[B_SETUP]           = rx_setup;
        end
        if (tx_hit) begin
            nxt[B_TXDONE]          = 1'b1;
            nxt[B_TXTGL]           = ~nxt[B_TXTGL];
            nxt[B_TXST_H:B_TXST_L] = ST_NAK;
        end
    end

    // Purpose: hold the word; synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    p_rx_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_hit |=> (q[B_RXDONE] && q[B_RXST_H:B_RXST_L] == ST_NAK));
    p_tx_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_hit |=> (q[B_TXDONE] && q[B_TXST_H:B_TXST_L] == ST_NAK));
    p_setup_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_hit |=> $stable(q[B_SETUP]));
    p_flag_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wdata[B_TXDONE] && tx_hit) |=> q[B_TXDONE]);
    p_no_spurious_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_hit |=> !$rose(q[B_RXDONE]));

endmodule

// File: rtl/usb_epreg_bank.sv
// Module: endpoint control register bank (top).
// Holds NUM_EP endpoint words at byte offsets 4*n and the descriptor-table
// base at TBL_OFF. Decodes the receive descriptor and blocks OUT events
// that overflow it. Reads are combinational; writes and events land on
// the clock edge. Assumes 4*(NUM_EP-1) < TBL_OFF.
module usb_epreg_bank
    import usbep_pkg::*;
#(
    parameter int NUM_EP = 8,
    parameter int ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_we,
    input  logic [WORD_W-1:0]        bus_wdata,
    output logic [WORD_W-1:0]        bus_rdata,
    input  logic [3:0]               ev_ep,
    input  logic                     ev_rx,
    input  logic                     ev_setup,
    input  logic                     ev_tx,
    input  logic [WORD_W-1:0]        ev_desc,
    output logic [CAP_W-1:0]         rx_cap_o,
    output logic                     rx_ovf_o,
    output logic [NUM_EP*WORD_W-1:0] ep_regs_o
);

    localparam logic [ADDR_W-1:0] TBL_OFF = ADDR_W'(8'h50);

    logic [WORD_W-1:0] ep_q [NUM_EP];
    logic [WORD_W-4:0] tbl_base;
    logic              ovf_now;
    logic              rx_ok;

    usbep_cap_decode u_cap (
        .desc (ev_desc),
        .cap  (rx_cap_o)
    );

    // Purpose: flag an OUT event whose byte count exceeds the decoded capacity.
    always_comb begin
        ovf_now = ev_rx && ({1'b0, ev_desc[9:0]} > rx_cap_o);
        rx_ok   = ev_rx && !ovf_now;
    end

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        logic sel_wr;
        logic hit_ep;
        assign sel_wr = bus_we && (bus_addr == ADDR_W'(4 * i));
        assign hit_ep = (ev_ep == 4'(i));

        usbep_ep_word u_word (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (sel_wr),
            .wdata    (bus_wdata),
            .rx_hit   (rx_ok && hit_ep),
            .rx_setup (ev_setup),
            .tx_hit   (ev_tx && hit_ep),
            .q        (ep_q[i])
        );

        assign ep_regs_o[i*WORD_W +: WORD_W] = ep_q[i];
    end

    // Purpose: table base register; the low three bits are not stored.
    always_ff @(posedge clk) begin
        if (!rst_n)                              tbl_base <= '0;
        else if (bus_we && bus_addr == TBL_OFF)  tbl_base <= bus_wdata[WORD_W-1:3];
    end

    // Purpose: register the overflow pulse for the cycle after the event.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_ovf_o <= 1'b0;
        else        rx_ovf_o <= ovf_now;
    end

    // Purpose: combinational read mux; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NUM_EP; k++) begin
            if (bus_addr == ADDR_W'(4 * k)) bus_rdata = ep_q[k];
        end
        if (bus_addr == TBL_OFF) bus_rdata = {tbl_base, 3'b000};
    end

    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf_o |-> $past(ev_rx));
    p_base_low_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == TBL_OFF) |-> (bus_rdata[2:0] == 3'b000));

endmodule

// File: tb/usb_epreg_bank_test.sv
module usb_epreg_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  ev_ep = '0;
    logic        ev_rx = 1'b0, ev_setup = 1'b0, ev_tx = 1'b0;
    logic [15:0] ev_desc = '0;
    logic [10:0] rx_cap_o;
    logic        rx_ovf_o;
    logic [127:0] ep_regs_o;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    usb_epreg_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_ep(ev_ep),
        .ev_rx(ev_rx), .ev_setup(ev_setup), .ev_tx(ev_tx), .ev_desc(ev_desc),
        .rx_cap_o(rx_cap_o), .rx_ovf_o(rx_ovf_o), .ep_regs_o(ep_regs_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic t_reset;
        logic [15:0] d;
        for (int i = 0; i < 8; i++) begin
            rd(8'(4 * i), d);
            chk("R1 ep word", d, 16'h0000);
        end
        rd(8'h50, d);
        chk("R1 base", d, 16'h0000);
        chk("R1 ovf", {15'd0, rx_ovf_o}, 16'h0000);
    endtask

    task automatic t_rw;
        logic [15:0] d;
        wr(8'h08, 16'h0705);
        rd(8'h08, d);
        chk("R2 type/kind/addr", d, 16'h0705);
    endtask

    task automatic t_toggle;
        logic [15:0] d;
        wr(8'h08, 16'h3725);
        rd(8'h08, d);
        chk("R3 stat invert", d, 16'h3725);
        wr(8'h08, 16'h1705);
        rd(8'h08, d);
        chk("R3 rx stat to NAK", d, 16'h2725);
        wr(8'h08, 16'h4745);
        rd(8'h08, d);
        chk("R3 toggles", d, 16'h6765);
    endtask

    task automatic t_setup_ro;
        logic [15:0] d;
        wr(8'h08, 16'h0F05);
        rd(8'h08, d);
        chk("R5 setup write ignored", d, 16'h6765);
    endtask

    task automatic t_rx_event;
        logic [15:0] d;
        @(negedge clk);
        ev_ep = 4'd2; ev_rx = 1'b1; ev_setup = 1'b1;
        ev_desc = (16'd4 << 10) | 16'd8;
        @(negedge clk);
        ev_rx = 1'b0; ev_setup = 1'b0;
        rd(8'h08, d);
        chk("R7 rx event", d, 16'hAF65);
        rd(8'h04, d);
        chk("R7 other ep untouched", d, 16'h0000);
        chk("R11 no ovf in range", {15'd0, rx_ovf_o}, 16'h0000);
    endtask

    task automatic t_clear;
        logic [15:0] d;
        wr(8'h08, 16'h8705);
        rd(8'h08, d);
        chk("R4 write 1 keeps", d, 16'hAF65);
        wr(8'h08, 16'h0705);
        rd(8'h08, d);
        chk("R4 write 0 clears", d, 16'h2F65);
    endtask

    task automatic t_tx_event;
        logic [15:0] d;
        wr(8'h08, 16'h0715);
        rd(8'h08, d);
        chk("R3 tx stat valid", d, 16'h2F75);
        @(negedge clk);
        ev_ep = 4'd2; ev_tx = 1'b1;
        @(negedge clk);
        ev_tx = 1'b0;
        rd(8'h08, d);
        chk("R8 tx event", d, 16'h2FA5);
    endtask

    task automatic t_race;
        logic [15:0] d;
        @(negedge clk);
        bus_addr = 8'h08; bus_wdata = 16'h0705; bus_we = 1'b1;
        ev_ep = 4'd2; ev_tx = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; ev_tx = 1'b0;
        rd(8'h08, d);
        chk("R9 hw set wins", d, 16'h2FE5);
    endtask

    task automatic t_base;
        logic [15:0] d;
        wr(8'h50, 16'hABCF);
        rd(8'h50, d);
        chk("R6 base low bits", d, 16'hABC8);
        rd(8'h54, d);
        chk("R6 unmapped", d, 16'h0000);
        rd(8'h20, d);
        chk("R6 absent ep", d, 16'h0000);
    endtask

    task automatic t_cap;
        ev_rx = 1'b0;
        ev_desc = 16'h0000; #1; chk("R10 zero", {5'd0, rx_cap_o}, 16'd0);
        ev_desc = 16'h7C00; #1; chk("R10 small max", {5'd0, rx_cap_o}, 16'd62);
        ev_desc = 16'h8000; #1; chk("R10 big one", {5'd0, rx_cap_o}, 16'd32);
        ev_desc = 16'h8400; #1; chk("R10 big two", {5'd0, rx_cap_o}, 16'd64);
        ev_desc = 16'hFC00; #1; chk("R10 big max", {5'd0, rx_cap_o}, 16'd1024);
    endtask

    task automatic t_ovf;
        logic [15:0] d;
        @(negedge clk);
        ev_ep = 4'd3; ev_rx = 1'b1; ev_desc = (16'd1 << 10) | 16'd3;
        @(negedge clk);
        ev_rx = 1'b0;
        chk("R11 ovf pulse", {15'd0, rx_ovf_o}, 16'h0001);
        rd(8'h0C, d);
        chk("R11 word unchanged", d, 16'h0000);
        @(negedge clk);
        chk("R11 ovf one cycle", {15'd0, rx_ovf_o}, 16'h0000);
        ev_rx = 1'b1; ev_desc = (16'd1 << 10) | 16'd2;
        @(negedge clk);
        ev_rx = 1'b0;
        chk("R11 exact fit no ovf", {15'd0, rx_ovf_o}, 16'h0000);
        rd(8'h0C, d);
        chk("R7 exact fit accepted", d, 16'hE000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rw();
        t_toggle();
        t_setup_ro();
        t_rx_event();
        t_clear();
        t_tx_event();
        t_race();
        t_base();
        t_cap();
        t_ovf();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule